// File: doc/BRIEF.md
# Code Flash Parallel Programming Sequencer

This block controls the parallel programming and verify port of a small on-chip code flash. An external programmer presents an address, a data byte and a three-bit operation code, then strobes an active-low program pulse. On the release of that pulse the block starts a self-timed job. The job is a single byte write, the setting of one of three protection bits, or a whole-array erase. The erase is accepted only if the pulse was held low long enough with the erase operation selected. The same port also returns code bytes for verification and three fixed identification bytes.

Progress is visible two ways. The `rdy` output drops for the length of every job. While a byte write is still running, a verify read of the byte being written returns its top bit inverted, so a programmer can poll the data lines instead of watching `rdy`. The array is a byte-wide register file that powers up erased. The job lengths are cycle-count parameters, so a bench can run them short. The high-voltage programming enable is a plain digital input.

Top module: `flash_prog_ctrl`

## Requirements
- R1: After reset `rdy` is 1 and `err` is 0, and a verify read of any code byte returns FFh. The array and the protection bits are not touched by reset.
- R2: With `op_sel`=001 (byte write) and `hv_en`=1, a low-then-high pulse on `prog_n` starts a job. The design samples the rising level at a clock edge. `rdy` is 0 for exactly WRITE_CYC cycles after that edge, and the byte is stored when `rdy` returns to 1.
- R3: Verify uses `op_sel`=010, and `dout` is registered, so it shows the result one clock after the address and operation are applied. While a byte write is running, a verify of its address returns the written byte with bit 7 inverted. Other addresses read true data.
- R4: A byte write to a location that does not read FFh leaves it unchanged. The job still runs its full WRITE_CYC cycles.
- R5: With `op_sel`=011 and `prog_n` held low for at least ERASE_HOLD clock edges, the release starts an erase. The erase keeps `rdy` at 0 for 2^ADDR_W cycles, sets every byte to FFh and clears all three protection bits. A shorter hold starts nothing.
- R6: `op_sel`=100, 101 and 110 set protection bit 1, 2 and 3, each in a WRITE_CYC-cycle job. While bit 1 or bit 2 is set, a verify returns FFh. Bit 3 does not affect reads.
- R7: With `op_sel`=111, addresses 030h, 031h and 032h return 1Eh, 51h, and FFh when HV_PART=1 or 05h when HV_PART=0. Every other address returns FFh. The protection bits do not block these reads.
- R8: A rising edge of `prog_n` during a job is ignored: the running job and its address are unaffected. It also sets `err`, which stays 1 until reset.
- R9: With `hv_en`=0 a program pulse starts no job and changes no byte.
- R10: With `op_sel` at 000 or at any write, erase or protection-bit code, `dout` is FFh.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| hv_en | input | 1 | Programming voltage present |
| op_sel | input | 3 | Operation code |
| addr | input | ADDR_W | Byte address |
| din | input | DATA_W | Byte to program |
| prog_n | input | 1 | Active-low program pulse |
| dout | output | DATA_W | Registered read data |
| rdy | output | 1 | 1 = ready, 0 = job running |
| err | output | 1 | Sticky flag: pulse arrived while busy |

## Verification
A vector table writes bytes with mixed bit patterns at the lowest address, the highest address, an address that overlaps the identification range and a mid-array address. Each byte is read back, which shows that writes land where addressed and that the identification mux does not leak into code reads. Polling is tried on a byte whose top bit is 1, against a neighbouring address read at the same time, which separates the inverted top bit from true data. Erase is tried with a hold one edge short and with the exact minimum, which pins the qualifying threshold. Protection bits 3 and then 1 are set in turn, which shows that only bits 1 and 2 blank the verify data.

// File: rtl/fpc_pkg.sv
package fpc_pkg;
   typedef enum logic [2:0] {
      OP_IDLE   = 3'd0,
      OP_WRITE  = 3'd1,
      OP_VERIFY = 3'd2,
      OP_ERASE  = 3'd3,
      OP_LOCK1  = 3'd4,
      OP_LOCK2  = 3'd5,
      OP_LOCK3  = 3'd6,
      OP_SIG    = 3'd7
   } fpc_op_e;

   typedef enum logic [1:0] {
      JOB_BYTE  = 2'd0,
      JOB_LOCK  = 2'd1,
      JOB_ERASE = 2'd2
   } fpc_job_e;
endpackage

// File: rtl/fpc_array.sv
module fpc_array #(
   parameter int ADDR_W = 12,
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              we,
   input  logic [ADDR_W-1:0] waddr,
   input  logic [DATA_W-1:0] wdata,
   input  logic [ADDR_W-1:0] raddr,
   output logic [DATA_W-1:0] rdata,
   input  logic [ADDR_W-1:0] caddr,
   output logic [DATA_W-1:0] cdata
);
   localparam int DEPTH = 1 << ADDR_W;

   logic [DATA_W-1:0] mem [DEPTH];

   // nonvolatile cells: erased at power-up, untouched by reset
   initial begin
      for (int i = 0; i < DEPTH; i++) mem[i] = '1;
   end

   always_ff @(posedge clk) begin
      if (we) mem[waddr] <= wdata;
   end

   assign rdata = mem[raddr];
   assign cdata = mem[caddr];
endmodule

// File: rtl/fpc_seq.sv
module fpc_seq
   import fpc_pkg::*;
#(
   parameter int ADDR_W     = 12,
   parameter int DATA_W     = 8,
   parameter int WRITE_CYC  = 16,
   parameter int ERASE_HOLD = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  fpc_op_e           op,
   input  logic              prog_n,
   input  logic              hv_en,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0] din,
   input  logic [DATA_W-1:0] cur_data,
   output logic              busy,
   output logic              poll_on,
   output logic              err,
   output logic [2:0]        lock,
   output logic              we,
   output logic [ADDR_W-1:0] wa,
   output logic [DATA_W-1:0] wd,
   output logic [ADDR_W-1:0] pend_addr,
   output logic [DATA_W-1:0] pend_data
);
   localparam int DEPTH = 1 << ADDR_W;
   localparam int WB    = (WRITE_CYC > 2) ? $clog2(WRITE_CYC) : 1;
   localparam int CW    = (ADDR_W > WB) ? ADDR_W : WB;
   localparam int HW    = $clog2(ERASE_HOLD + 1);

   logic          prog_q;
   logic          rise;
   logic [HW-1:0] hold_q;
   logic [CW-1:0] cnt_q;
   fpc_job_e      job_q;
   logic [2:0]    lock_q = '0;
   logic          done;

   assign rise = !prog_q && prog_n;
   assign done = busy && (cnt_q == '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         prog_q    <= 1'b1;
         hold_q    <= '0;
         cnt_q     <= '0;
         busy      <= 1'b0;
         err       <= 1'b0;
         job_q     <= JOB_BYTE;
         pend_addr <= '0;
         pend_data <= '0;
      end else begin
         prog_q <= prog_n;
         if (!prog_n && op == OP_ERASE) begin
            if (hold_q < HW'(ERASE_HOLD)) hold_q <= hold_q + 1'b1;
         end else begin
            hold_q <= '0;
         end
         if (busy) begin
            if (cnt_q == '0) busy <= 1'b0;
            else             cnt_q <= cnt_q - 1'b1;
            if (rise) err <= 1'b1;
         end else if (rise && hv_en) begin
            case (op)
               OP_WRITE: begin
                  busy      <= 1'b1;
                  job_q     <= JOB_BYTE;
                  cnt_q     <= CW'(WRITE_CYC - 1);
                  pend_addr <= addr;
                  pend_data <= din;
               end
               OP_LOCK1, OP_LOCK2, OP_LOCK3: begin
                  busy      <= 1'b1;
                  job_q     <= JOB_LOCK;
                  cnt_q     <= CW'(WRITE_CYC - 1);
                  pend_data <= DATA_W'(op - OP_LOCK1);
               end
               OP_ERASE: begin
                  if (hold_q >= HW'(ERASE_HOLD)) begin
                     busy  <= 1'b1;
                     job_q <= JOB_ERASE;
                     cnt_q <= CW'(DEPTH - 1);
                  end
               end
               default: ;
            endcase
         end
      end
   end

   // protection bits are nonvolatile: no reset
   always_ff @(posedge clk) begin
      if (done && job_q == JOB_LOCK)  lock_q[pend_data[1:0]] <= 1'b1;
      if (done && job_q == JOB_ERASE) lock_q <= '0;
   end

   assign lock    = lock_q;
   assign poll_on = busy && job_q == JOB_BYTE;
   assign we      = (job_q == JOB_ERASE) ? busy
                                         : (done && job_q == JOB_BYTE && cur_data == '1);
   assign wa      = (job_q == JOB_ERASE) ? cnt_q[ADDR_W-1:0] : pend_addr;
   assign wd      = (job_q == JOB_ERASE) ? '1 : pend_data;

   // R8
   err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      err |=> err);
   // R8
   busy_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && rise) |=> ($stable(pend_addr) && err));
   // R2
   busy_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rise && !busy && hv_en && op == OP_WRITE) |=> (busy && pend_addr == $past(addr)));
   // R5
   short_erase_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rise && !busy && op == OP_ERASE && hold_q < HW'(ERASE_HOLD)) |=> !busy);
   // R9
   no_hv_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rise && !busy && !hv_en) |=> !busy);
endmodule

// File: rtl/fpc_rdpath.sv
module fpc_rdpath
   import fpc_pkg::*;
#(
   parameter int ADDR_W  = 12,
   parameter int DATA_W  = 8,
   parameter bit HV_PART = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  fpc_op_e           op,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0] mem_q,
   input  logic              poll_on,
   input  logic [ADDR_W-1:0] pend_addr,
   input  logic [DATA_W-1:0] pend_data,
   input  logic [2:0]        lock,
   output logic [DATA_W-1:0] dout
);
   logic [DATA_W-1:0] sig_last;
   logic [DATA_W-1:0] nxt;

   generate
      if (HV_PART) begin : g_hv
         assign sig_last = DATA_W'(8'hFF);
      end else begin : g_lv
         assign sig_last = DATA_W'(8'h05);
      end
   endgenerate

   always_comb begin
      nxt = '1;
      case (op)
         OP_VERIFY: begin
            if (lock[0] || lock[1])
               nxt = '1;
            else if (poll_on && addr == pend_addr)
               nxt = {~pend_data[DATA_W-1], pend_data[DATA_W-2:0]};
            else
               nxt = mem_q;
         end
         OP_SIG: begin
            case (addr)
               ADDR_W'(12'h030): nxt = DATA_W'(8'h1E);
               ADDR_W'(12'h031): nxt = DATA_W'(8'h51);
               ADDR_W'(12'h032): nxt = sig_last;
               default:          nxt = '1;
            endcase
         end
         default: nxt = '1;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) dout <= '1;
      else        dout <= nxt;
   end

   // R6
   locked_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (op == OP_VERIFY && (lock[0] || lock[1])) |=> dout == '1);
   // R10
   idle_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (op != OP_VERIFY && op != OP_SIG) |=> dout == '1);
endmodule

// File: rtl/flash_prog_ctrl.sv
module flash_prog_ctrl
   import fpc_pkg::*;
#(
   parameter int ADDR_W     = 12,
   parameter int DATA_W     = 8,
   parameter int WRITE_CYC  = 16,
   parameter int ERASE_HOLD = 32,
   parameter bit HV_PART    = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              hv_en,
   input  logic [2:0]        op_sel,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0] din,
   input  logic              prog_n,
   output logic [DATA_W-1:0] dout,
   output logic              rdy,
   output logic              err
);
   generate
      if (ADDR_W < 6 || ADDR_W > 16) begin : g_bad_aw
         $error("ADDR_W must cover the identification bytes and stay small");
      end
      if (DATA_W != 8) begin : g_bad_dw
         $error("DATA_W must be 8");
      end
      if (WRITE_CYC < 2) begin : g_bad_wc
         $error("WRITE_CYC must be at least 2");
      end
      if (ERASE_HOLD < 1) begin : g_bad_eh
         $error("ERASE_HOLD must be at least 1");
      end
   endgenerate

   fpc_op_e           op;
   logic              busy, poll_on, we;
   logic [2:0]        lock;
   logic [ADDR_W-1:0] wa, pend_addr;
   logic [DATA_W-1:0] wd, pend_data, mem_q, cur_data;

   assign op  = fpc_op_e'(op_sel);
   assign rdy = !busy;

   fpc_array #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_array (
      .clk(clk), .we(we), .waddr(wa), .wdata(wd),
      .raddr(addr), .rdata(mem_q), .caddr(pend_addr), .cdata(cur_data)
   );

   fpc_seq #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .WRITE_CYC(WRITE_CYC),
             .ERASE_HOLD(ERASE_HOLD)) u_seq (
      .clk(clk), .rst_n(rst_n), .op(op), .prog_n(prog_n), .hv_en(hv_en),
      .addr(addr), .din(din), .cur_data(cur_data), .busy(busy),
      .poll_on(poll_on), .err(err), .lock(lock), .we(we), .wa(wa), .wd(wd),
      .pend_addr(pend_addr), .pend_data(pend_data)
   );

   fpc_rdpath #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .HV_PART(HV_PART)) u_rd (
      .clk(clk), .rst_n(rst_n), .op(op), .addr(addr), .mem_q(mem_q),
      .poll_on(poll_on), .pend_addr(pend_addr), .pend_data(pend_data),
      .lock(lock), .dout(dout)
   );
endmodule

// File: tb/flash_prog_ctrl_tb.sv
module flash_prog_ctrl_tb;
   localparam int WC = 8;
   localparam int EH = 12;
   localparam int AW = 12;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       hv_en = 1'b1;
   logic [2:0] op_sel = 3'd0;
   logic [11:0] addr = '0;
   logic [7:0] din = '0;
   logic       prog_n = 1'b1;
   logic [7:0] dout;
   logic       rdy, err;
   int total = 0;
   int bad = 0;
   int n;

   always #5 clk = ~clk;

   flash_prog_ctrl #(.ADDR_W(AW), .DATA_W(8), .WRITE_CYC(WC),
                     .ERASE_HOLD(EH), .HV_PART(1'b1)) u_dut (
      .clk(clk), .rst_n(rst_n), .hv_en(hv_en), .op_sel(op_sel), .addr(addr),
      .din(din), .prog_n(prog_n), .dout(dout), .rdy(rdy), .err(err)
   );

   // {op, addr, din, expected}
   localparam logic [30:0] VEC [9] = '{
      {3'd1, 12'h000, 8'h3C, 8'h3C},
      {3'd1, 12'hFFF, 8'h81, 8'h81},
      {3'd1, 12'h030, 8'h00, 8'h00},
      {3'd1, 12'h7AA, 8'h5A, 8'h5A},
      {3'd7, 12'h030, 8'h00, 8'h1E},
      {3'd7, 12'h031, 8'h00, 8'h51},
      {3'd7, 12'h032, 8'h00, 8'hFF},
      {3'd7, 12'h033, 8'h00, 8'hFF},
      {3'd7, 12'h000, 8'h00, 8'hFF}
   };

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
      end
   endtask

   task automatic rd(input logic [2:0] o, input logic [11:0] a, output logic [7:0] v);
      @(negedge clk);
      op_sel = o; addr = a;
      @(negedge clk);
      v = dout;
   endtask

   task automatic pulse(input logic [2:0] o, input logic [11:0] a, input logic [7:0] d,
                        input int low);
      @(negedge clk);
      op_sel = o; addr = a; din = d; prog_n = 1'b0;
      repeat (low) @(negedge clk);
      prog_n = 1'b1;
   endtask

   task automatic wait_rdy(output int cnt);
      cnt = 0;
      @(negedge clk);
      while (!rdy && cnt < 20000) begin
         cnt++;
         @(negedge clk);
      end
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      bad++; total++;
      $display("FAIL watchdog act=hung exp=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      logic [7:0] v;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      // R1 reset state
      chk("R1 rdy", rdy, 1);
      chk("R1 err", err, 0);
      rd(3'd2, 12'h555, v); chk("R1 erased byte", v, 8'hFF);
      // R10 idle op
      rd(3'd0, 12'h555, v); chk("R10 idle dout", v, 8'hFF);

      // table: R2 writes and R7 signature
      foreach (VEC[i]) begin
         if (VEC[i][30:28] == 3'd1) begin
            pulse(3'd1, VEC[i][27:16], VEC[i][15:8], 1);
            wait_rdy(n);
            chk("R2 busy length", n, WC);
            rd(3'd2, VEC[i][27:16], v);
            chk("R2 stored byte", v, VEC[i][7:0]);
         end else begin
            rd(VEC[i][30:28], VEC[i][27:16], v);
            chk("R7 signature", v, VEC[i][7:0]);
         end
      end

      // R3 polling
      pulse(3'd1, 12'h123, 8'hA5, 1);
      @(negedge clk);
      chk("R3 busy seen", rdy, 0);
      rd(3'd2, 12'h123, v); chk("R3 polled bit7", v, 8'h25);
      rd(3'd2, 12'h000, v); chk("R3 other addr true", v, 8'h3C);
      wait_rdy(n);
      rd(3'd2, 12'h123, v); chk("R3 true after done", v, 8'hA5);

      // R4 non-blank rewrite
      pulse(3'd1, 12'h123, 8'h00, 1);
      wait_rdy(n);
      chk("R4 busy length", n, WC);
      rd(3'd2, 12'h123, v); chk("R4 unchanged", v, 8'hA5);

      // R8 pulse during busy
      chk("R8 err clear before", err, 0);
      pulse(3'd1, 12'h200, 8'h11, 1);
      @(negedge clk); @(negedge clk);
      pulse(3'd1, 12'h300, 8'h22, 1);
      wait_rdy(n);
      chk("R8 err set", err, 1);
      rd(3'd2, 12'h200, v); chk("R8 first kept", v, 8'h11);
      rd(3'd2, 12'h300, v); chk("R8 second ignored", v, 8'hFF);

      // R9 no programming voltage
      hv_en = 1'b0;
      pulse(3'd1, 12'h400, 8'h44, 1);
      wait_rdy(n);
      chk("R9 no busy", n, 0);
      rd(3'd2, 12'h400, v); chk("R9 byte untouched", v, 8'hFF);
      hv_en = 1'b1;

      // R6 lock 3 leaves reads open, lock 1 blanks them
      pulse(3'd6, 12'h000, 8'h00, 1);
      wait_rdy(n);
      chk("R6 lock3 busy", n, WC);
      rd(3'd2, 12'h123, v); chk("R6 lock3 no effect", v, 8'hA5);
      pulse(3'd4, 12'h000, 8'h00, 1);
      wait_rdy(n);
      rd(3'd2, 12'h123, v); chk("R6 lock1 blanks", v, 8'hFF);
      rd(3'd7, 12'h031, v); chk("R7 sig under lock", v, 8'h51);
      rd(3'd1, 12'h123, v); chk("R10 write op dout", v, 8'hFF);

      // R5 erase: short hold ignored, exact hold accepted
      pulse(3'd3, 12'h000, 8'h00, EH - 1);
      wait_rdy(n);
      chk("R5 short hold", n, 0);
      pulse(3'd3, 12'h000, 8'h00, EH);
      wait_rdy(n);
      chk("R5 erase length", n, 1 << AW);
      rd(3'd2, 12'h123, v); chk("R5 erased and unlocked", v, 8'hFF);
      rd(3'd2, 12'h000, v); chk("R5 low byte erased", v, 8'hFF);
      rd(3'd2, 12'hFFF, v); chk("R5 top byte erased", v, 8'hFF);
      chk("R8 err still set", err, 1);
      pulse(3'd1, 12'h123, 8'h5A, 1);
      wait_rdy(n);
      rd(3'd2, 12'h123, v); chk("R5 rewrite after erase", v, 8'h5A);

      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule